// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer reached through a plain 32-bit register bus with four word registers: a mode register, a counter setup register, a restart register and a status register. Every write that changes the mode or the counter setup must carry a fixed key pattern in its upper bits. A write whose key does not match is dropped, and it leaves all state as it was. The restart register only reacts to one exact 32-bit word.

Once enabled, a down-counter steps once per prescaled tick. The prescaler divides the bus clock by 8, 64, 512 or 4096. A valid restart reloads the counter from a 12-bit coarse field, with the low part filled with ones, and it clears the prescaler. When the counter steps onto zero, the block flags the expiry in status. If enabled, it also sends out a reset pulse of programmable width, an interrupt level, or both. Software services the block by writing the restart word before the expiry. Writing a keyed mode word with the enable bit clear stops the watchdog.

The parameter `LOW_W` sets the width of the all-ones fill below the coarse field. Its default of 12 makes each coarse unit worth 0x1000 ticks.

Top module: `wdg_keyed_timer`

## Requirements
- R1: A write to offset 0x0 updates the mode register only when data bits [23:12] equal 0xABC. The fields are: bit 0 enable, bit 1 reset-output enable, bit 2 interrupt enable, bits [5:4] pulse code. A read of 0x0 returns these fields in the same positions and zero elsewhere.
- R2: A write to offset 0x4 updates the counter setup only when data bits [25:14] equal 0x248. Bits [13:2] hold the 12-bit coarse reload value and bits [1:0] hold the prescaler select. A read of 0x4 returns these fields in the same positions.
- R3: Only a write of exactly 0x00001999 to offset 0x8 restarts. A restart loads the counter with {coarse value, LOW_W ones} and clears the prescaler. Any other word written there has no effect.
- R4: Prescaler select codes 0, 1, 2 and 3 divide the bus clock by 8, 64, 512 and 4096.
- R5: While enabled, the counter reaches zero L*D bus cycles after the restart write edge. L is the loaded count and D is the divide ratio.
- R6: When reset-output enable is set, reaching zero drives the reset output high for 2, 4, 8 or 16 cycles for pulse codes 0 to 3. With reset-output enable clear, the reset output stays low.
- R7: When interrupt enable is set, reaching zero raises the interrupt output. The interrupt holds high until the next valid restart.
- R8: Bit 0 of the status register (offset 0xC) reads 1 from the cycle the counter reaches zero until the next valid restart.
- R9: While enable is 0, the counter does not step, and no expiry occurs however long the block waits.
- R10: A mode or counter setup write with a wrong key changes no register.
- R11: After reset, all registers read 0, and the reset and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable; read data is zero when low |
| bus_addr | input | 4 | Byte offset of the word register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address and state |
| wdt_rst_o | output | 1 | Timeout reset pulse |
| wdt_irq_o | output | 1 | Timeout interrupt level |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data follows the address with no clock, so the bench reads and checks registers at the falling edge after a write. A restart at edge E lets status, interrupt and the start of the reset pulse change at edge E+L*D. The bench checks each one half a cycle before that edge and again half a cycle after it. It checks the pulse the same way at its last high cycle and the cycle that follows. The bench shrinks `LOW_W` to 4 so that every divide ratio finishes in a short run, and the expected expiry cycles come from (16*coarse+15)*D.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

    localparam int BUS_W  = 32;
    localparam int ADDR_W = 4;
    localparam int CRV_W  = 12;
    localparam int PRE_W  = 12;
    localparam int PLS_W  = 5;

    localparam logic [ADDR_W-1:0] OFF_MODE    = 4'h0;
    localparam logic [ADDR_W-1:0] OFF_SETUP   = 4'h4;
    localparam logic [ADDR_W-1:0] OFF_KICK    = 4'h8;
    localparam logic [ADDR_W-1:0] OFF_STATUS  = 4'hC;

    localparam logic [11:0]      MODE_KEY    = 12'hABC;
    localparam logic [11:0]      SETUP_KEY   = 12'h248;
    localparam logic [BUS_W-1:0] KICK_WORD   = 32'h0000_1999;

    typedef enum logic [1:0] {
        DIV_8    = 2'd0,
        DIV_64   = 2'd1,
        DIV_512  = 2'd2,
        DIV_4096 = 2'd3
    } psel_e;

    typedef struct packed {
        logic       en;
        logic       rst_en;
        logic       irq_en;
        logic [1:0] plen;
    } mode_t;

    typedef struct packed {
        logic [CRV_W-1:0] crv;
        psel_e            psel;
    } setup_t;

    function automatic logic [PRE_W-1:0] last_phase(input psel_e s);
        case (s)
            DIV_8:    return 12'd7;
            DIV_64:   return 12'd63;
            DIV_512:  return 12'd511;
            default:  return 12'd4095;
        endcase
    endfunction

    function automatic logic [PLS_W-1:0] pulse_cycles(input logic [1:0] c);
        case (c)
            2'd0:    return 5'd2;
            2'd1:    return 5'd4;
            2'd2:    return 5'd8;
            default: return 5'd16;
        endcase
    endfunction

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
    import wdg_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [BUS_W-1:0]    bus_wdata,
    input  logic                expired,
    output mode_t               mode,
    output setup_t              setup,
    output logic                kick,
    output logic [BUS_W-1:0]    bus_rdata
);

    mode_t  mode_q;
    setup_t setup_q;

    logic mode_hit, setup_hit, mode_ok, setup_ok;

    assign mode_hit  = bus_wr && (bus_addr == OFF_MODE);
    assign setup_hit = bus_wr && (bus_addr == OFF_SETUP);
    assign mode_ok   = mode_hit  && (bus_wdata[23:12] == MODE_KEY);
    assign setup_ok  = setup_hit && (bus_wdata[25:14] == SETUP_KEY);
    assign kick      = bus_wr && (bus_addr == OFF_KICK) && (bus_wdata == KICK_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (mode_ok) begin
            mode_q.en     <= bus_wdata[0];
            mode_q.rst_en <= bus_wdata[1];
            mode_q.irq_en <= bus_wdata[2];
            mode_q.plen   <= bus_wdata[5:4];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= '{crv: '0, psel: DIV_8};
        end else if (setup_ok) begin
            setup_q.crv  <= bus_wdata[13:2];
            setup_q.psel <= psel_e'(bus_wdata[1:0]);
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                OFF_MODE:   bus_rdata = {26'b0, mode_q.plen, 1'b0,
                                         mode_q.irq_en, mode_q.rst_en, mode_q.en};
                OFF_SETUP:  bus_rdata = {18'b0, setup_q.crv, setup_q.psel};
                OFF_STATUS: bus_rdata = {31'b0, expired};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign mode  = mode_q;
    assign setup = setup_q;

    // R10
    mode_badkey_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_hit && !mode_ok) |=> $stable(mode_q));

    // R10
    setup_badkey_chk: assert property (@(posedge clk) disable iff (rst)
        (setup_hit && !setup_ok) |=> $stable(setup_q));

endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler
    import wdg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  kick,
    input  psel_e psel,
    output logic  tick
);

    logic [PRE_W-1:0] phase_q;

    assign tick = en && (phase_q >= last_phase(psel));

    always_ff @(posedge clk) begin
        if (rst || kick || !en || tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // R4: the smallest ratio is 8, so ticks never come back to back
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R9
    idle_phase_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase_q == '0));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter
    import wdg_pkg::*;
#(
    parameter int LOW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             kick,
    input  mode_t            mode,
    input  logic [CRV_W-1:0] crv,
    output logic             expired,
    output logic             irq,
    output logic             rst_pulse
);

    localparam int CW = CRV_W + LOW_W;

    logic [CW-1:0]    count_q;
    logic [PLS_W-1:0] pulse_q;
    logic             expired_q, irq_q;
    logic             zero_evt;

    assign zero_evt = mode.en && tick && !kick && (count_q == CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= {{CRV_W{1'b0}}, {LOW_W{1'b1}}};
        end else if (kick) begin
            count_q <= {crv, {LOW_W{1'b1}}};
        end else if (mode.en && tick && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || kick) begin
            expired_q <= 1'b0;
            irq_q     <= 1'b0;
        end else if (zero_evt) begin
            expired_q <= 1'b1;
            irq_q     <= mode.irq_en;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_q <= '0;
        end else if (zero_evt && mode.rst_en) begin
            pulse_q <= pulse_cycles(mode.plen);
        end else if (pulse_q != '0) begin
            pulse_q <= pulse_q - 1'b1;
        end
    end

    assign expired   = expired_q;
    assign irq       = irq_q;
    assign rst_pulse = (pulse_q != '0);

    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        !kick |=> (count_q <= $past(count_q)));

    // R9
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode.en && !kick) |=> $stable(count_q));

    // R6
    pulse_bound_chk: assert property (@(posedge clk) disable iff (rst)
        pulse_q <= PLS_W'(16));

    // R7
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_q && !kick) |=> irq_q);

    // R8
    status_zero_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(expired_q) |-> (count_q == '0));

endmodule

// File: rtl/wdg_keyed_timer.sv
module wdg_keyed_timer
    import wdg_pkg::*;
#(
    parameter int LOW_W = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        wdt_rst_o,
    output logic        wdt_irq_o
);

    mode_t  mode;
    setup_t setup;
    logic   kick, tick, expired;

    wdg_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .expired   (expired),
        .mode      (mode),
        .setup     (setup),
        .kick      (kick),
        .bus_rdata (bus_rdata)
    );

    wdg_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (mode.en),
        .kick (kick),
        .psel (setup.psel),
        .tick (tick)
    );

    wdg_counter #(.LOW_W(LOW_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .kick      (kick),
        .mode      (mode),
        .crv       (setup.crv),
        .expired   (expired),
        .irq       (wdt_irq_o),
        .rst_pulse (wdt_rst_o)
    );

    // R6
    no_pulse_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode.rst_en && !wdt_rst_o) |=> !$rose(wdt_rst_o));

endmodule

// File: tb/wdg_keyed_timer_tb.sv
module wdg_keyed_timer_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr, bus_rd;
    logic [3:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        wdt_rst_o, wdt_irq_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    wdg_keyed_timer #(.LOW_W(4)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wdt_rst_o (wdt_rst_o),
        .wdt_irq_o (wdt_irq_o)
    );

    // vectors: coarse value, select, pulse code, expiry cycles, pulse cycles
    localparam int NV = 5;
    localparam int V_CRV  [NV] = '{1, 0, 2, 0, 0};
    localparam int V_SEL  [NV] = '{0, 1, 0, 2, 3};
    localparam int V_PLEN [NV] = '{0, 1, 3, 2, 0};
    localparam int V_CYC  [NV] = '{248, 960, 376, 7680, 61440};
    localparam int V_PULSE[NV] = '{2, 4, 16, 8, 2};

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    function automatic logic [31:0] mode_word(input int en, input int re, input int ie, input int pl);
        return 32'h00AB_C000 | 32'(pl << 4) | 32'(ie << 2) | 32'(re << 1) | 32'(en);
    endfunction

    function automatic logic [31:0] setup_word(input int crv, input int sel);
        return 32'h0092_0000 | 32'(crv << 2) | 32'(sel);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        chk("R11 rst out", {31'b0, wdt_rst_o}, 0);
        chk("R11 irq out", {31'b0, wdt_irq_o}, 0);
        bread(4'h0, rd); chk("R11 mode", rd, 0);
        bread(4'h4, rd); chk("R11 setup", rd, 0);
        bread(4'hC, rd); chk("R11 status", rd, 0);

        // R10 wrong keys change nothing
        bwrite(4'h4, 32'h0093_0000 | 32'h3FFF);
        bread(4'h4, rd); chk("R10 R2 bad setup key", rd, 0);
        bwrite(4'h0, 32'h00AB_D037);
        bread(4'h0, rd); chk("R10 R1 bad mode key", rd, 0);

        // R1 R2 keyed writes read back in place
        bwrite(4'h4, setup_word(12'hA5C, 2));
        bread(4'h4, rd); chk("R2 setup readback", rd, 32'h0000_2972);
        bwrite(4'h0, mode_word(0, 1, 1, 2));
        bread(4'h0, rd); chk("R1 mode readback", rd, 32'h0000_0026);

        // vector walk: R3 R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            bwrite(4'h4, setup_word(V_CRV[v], V_SEL[v]));
            bwrite(4'h0, mode_word(1, 1, 1, V_PLEN[v]));
            bwrite(4'h8, 32'h0000_1999);
            wait_n(V_CYC[v] - 1);
            bread(4'hC, rd); chk("R5 R4 before zero", rd, 0);
            chk("R7 irq before zero", {31'b0, wdt_irq_o}, 0);
            wait_n(1);
            bread(4'hC, rd); chk("R8 R5 status at zero", rd, 1);
            chk("R7 irq at zero", {31'b0, wdt_irq_o}, 1);
            chk("R6 pulse start", {31'b0, wdt_rst_o}, 1);
            wait_n(V_PULSE[v] - 1);
            chk("R6 pulse last", {31'b0, wdt_rst_o}, 1);
            wait_n(1);
            chk("R6 pulse end", {31'b0, wdt_rst_o}, 0);
            chk("R7 irq held", {31'b0, wdt_irq_o}, 1);
            bwrite(4'h8, 32'h0000_1999);
            bread(4'hC, rd); chk("R8 R3 status cleared", rd, 0);
            chk("R7 irq cleared", {31'b0, wdt_irq_o}, 0);
            bwrite(4'h0, mode_word(0, 0, 0, 0));
        end

        // R3 wrong kick word ignored, R6 no pulse when disabled
        bwrite(4'h4, setup_word(1, 0));
        bwrite(4'h0, mode_word(1, 0, 1, 3));
        bwrite(4'h8, 32'h0000_1999);
        wait_n(99);
        bwrite(4'h8, 32'h0000_1998);
        wait_n(147);
        bread(4'hC, rd); chk("R3 bad kick no reload before", rd, 0);
        wait_n(1);
        bread(4'hC, rd); chk("R3 bad kick no reload at zero", rd, 1);
        chk("R7 irq only", {31'b0, wdt_irq_o}, 1);
        chk("R6 no pulse when off", {31'b0, wdt_rst_o}, 0);
        wait_n(20);
        chk("R6 still no pulse", {31'b0, wdt_rst_o}, 0);

        // R9 disabled counter never expires
        bwrite(4'h8, 32'h0000_1999);
        wait_n(100);
        bwrite(4'h0, mode_word(0, 1, 1, 0));
        wait_n(600);
        bread(4'hC, rd); chk("R9 no expiry while off", rd, 0);
        chk("R9 no irq while off", {31'b0, wdt_irq_o}, 0);
        chk("R9 no pulse while off", {31'b0, wdt_rst_o}, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule